// File: doc/BRIEF.md
# PHY USB3 Initialization Sequencer

This block brings a combined USB3/PCIe physical layer up in USB3 mode after power-up. A single-cycle `start` pulse makes it drive the PHY reset for a fixed number of clock cycles. It then sets the two-bit lane-mode field in a local register to select USB3. After that it walks a fixed list of five read-modify-write fixups on the PHY's internal control registers. At the end it programs the transmit boost and loss-of-signal detector fields in two more local registers.

Internal register traffic leaves through a command port. A bus master outside the block carries each command to the PHY's control-register bus and answers with a completion strobe, an error flag and read data. The sequencer keeps at most one command in flight. The first completion that carries an error ends the sequence: the error output rises, no further command is issued, and the analog-setting registers keep their reset values. Once the sequence has finished or failed, a new start runs it again.

Top module: `phy_usb3_init_seq`

## Requirements
- R1: A `start` pulse accepted in the idle, finished or failed state drives `phy_rst` high from the next cycle for exactly `RST_CYCLES` cycles.
- R2: While `phy_rst` is high no command is issued. After `phy_rst` falls and before the first command, bits 6:5 of `mode_cfg` become 2'b11 and all other bits of `mode_cfg` keep their reset value.
- R3: A successful run issues exactly ten commands, with `cmd_write`=0 for a read and 1 for a write. Each internal address is read and then written, and the addresses come in the order 0x102D, 0x1010, 0x1006, 0x1002, 0x0030.
- R4: The write to 0x102D equals the value read from it with bit 7 set.
- R5: The write to 0x1010 is the value read with bits 11:4 cleared, then ORed with decimal 20 (bits 4 and 2).
- R6: The write to 0x1006 has bit 6 = 0, bit 7 = 1, bits 10:8 = 3 and bit 11 = 1. Bits 15:12 and 5:0 are taken from the value read.
- R7: The write to 0x1002 has bits 6:0 = 127, bits 13:7 = 22 and bit 14 = 1. Bit 15 is taken from the value read.
- R8: The write to 0x0030 has bits 7:4 = 8, and all other bits are taken from the value read.
- R9: After the last write completes without error, three fields are set: `boost_cfg` bits 20:18 = 4, `los_cfg` bits 23:21 = 4 and `los_cfg` bits 20:16 = 9. All other bits keep their values. These registers change in no other cycle, and `done` rises in the cycle they change.
- R10: A completion with `rsp_err`=1 on any command raises `error`, keeps `done` low, stops all further commands and leaves `los_cfg` and `boost_cfg` at their reset values.
- R11: `cmd_valid` is a one-cycle pulse issued only when no command is outstanding. `cmd_addr`, `cmd_wdata` and `cmd_write` hold steady until the matching `rsp_done`.
- R12: An `rsp_done` (with or without `rsp_err`) that arrives while no command is outstanding has no effect.
- R13: `start` is ignored while a run is in progress. A `start` accepted after a finished run clears `done` and repeats the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to run the sequence |
| phy_rst | output | 1 | Active-high reset to the PHY |
| cmd_valid | output | 1 | One-cycle command strobe to the bus master |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 16 | Internal register address |
| cmd_wdata | output | 16 | Write data |
| rsp_done | input | 1 | Completion strobe from the bus master |
| rsp_err | input | 1 | Completion carries an error |
| rsp_rdata | input | 16 | Read data, valid with `rsp_done` |
| mode_cfg | output | 32 | Local register holding the lane-mode field |
| los_cfg | output | 32 | Local register holding the loss-of-signal bias and level |
| boost_cfg | output | 32 | Local register holding transmit boost |
| done | output | 1 | Sequence completed |
| error | output | 1 | Sequence aborted on a bus error |

## Verification
The bench sweeps every internal register from several seed patterns under several response latencies, so that kept bits are seen at both 0 and 1. A masking error that clears or sets a bit the fixup should leave alone then shows up in the write data. It injects an error at each of the ten command positions. A design that ignores an error keeps issuing commands or reaches the analog step, and one that stops late issues one command too many. It also sends a stray completion while the reset is held, restarts after a finished run, and pulses `start` mid-run. These catch a block that takes phantom completions, fails to clear `done`, or restarts its reset in the middle of the sequence.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;

  localparam int CR_AW      = 16;
  localparam int CR_DW      = 16;
  localparam int NUM_FIXUPS = 5;
  localparam int STEP_W     = 3;

  // local register field positions (consumed by the PHY, so fixed)
  localparam int MODE_LSB  = 5;
  localparam int MODE_W    = 2;
  localparam int BOOST_LSB = 18;
  localparam int BOOST_W   = 3;
  localparam int BOOST_VAL = 4;
  localparam int LOSB_LSB  = 21;
  localparam int LOSB_W    = 3;
  localparam int LOSB_VAL  = 4;
  localparam int LOSL_LSB  = 16;
  localparam int LOSL_W    = 5;
  localparam int LOSL_VAL  = 9;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_MODE,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_WR_ISSUE,
    ST_WR_WAIT,
    ST_LOCAL,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  typedef struct packed {
    logic [CR_AW-1:0] addr;
    logic [CR_DW-1:0] clr;
    logic [CR_DW-1:0] set;
  } fixup_t;

  // ordered fixup list: address, bits to clear, bits to set
  function automatic fixup_t fixup_at(input logic [STEP_W-1:0] idx);
    fixup_t f;
    case (idx)
      3'd0:    f = '{addr: 16'h102D, clr: 16'h0000, set: 16'h0080};
      3'd1:    f = '{addr: 16'h1010, clr: 16'h0FF0, set: 16'h0014};
      3'd2:    f = '{addr: 16'h1006, clr: 16'h0740, set: 16'h0B80};
      3'd3:    f = '{addr: 16'h1002, clr: 16'h3FFF, set: 16'h4B7F};
      3'd4:    f = '{addr: 16'h0030, clr: 16'h00F0, set: 16'h0080};
      default: f = '{addr: 16'h0000, clr: 16'h0000, set: 16'h0000};
    endcase
    return f;
  endfunction

  function automatic logic [CR_DW-1:0] apply_fixup(input fixup_t f,
                                                   input logic [CR_DW-1:0] rd);
    return (rd & ~f.clr) | f.set;
  endfunction

endpackage

// File: rtl/phy_init_rst_timer.sv
module phy_init_rst_timer #(
  parameter int CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R1: the hold counter never exceeds its load value
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);

  // R1: a freshly loaded counter is not expired unless one cycle is asked for
  p_load_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/phy_init_cr_port.sv
module phy_init_cr_port
  import phy_init_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             issue_write,
  input  logic [CR_AW-1:0] issue_addr,
  input  logic [CR_DW-1:0] issue_wdata,
  input  logic             rsp_done,
  input  logic             rsp_err,
  input  logic [CR_DW-1:0] rsp_rdata,
  output logic             cmd_valid,
  output logic             cmd_write,
  output logic [CR_AW-1:0] cmd_addr,
  output logic [CR_DW-1:0] cmd_wdata,
  output logic             resp_ok,
  output logic             resp_fail,
  output logic [CR_DW-1:0] rd_data
);
  logic             valid_q;
  logic             write_q;
  logic [CR_AW-1:0] addr_q;
  logic [CR_DW-1:0] wdata_q;
  logic             outst_q, outst_d;
  logic [CR_DW-1:0] rd_q;
  logic             accept;
  logic             rd_en;

  always_comb begin
    accept  = rsp_done && outst_q;
    rd_en   = accept && !write_q && !rsp_err;
    outst_d = outst_q;
    if (issue)       outst_d = 1'b1;
    else if (accept) outst_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      outst_q <= 1'b0;
    end else begin
      valid_q <= issue;
      outst_q <= outst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (issue) begin
      write_q <= issue_write;
      addr_q  <= issue_addr;
      wdata_q <= issue_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rsp_rdata;
  end

  assign cmd_valid = valid_q;
  assign cmd_write = write_q;
  assign cmd_addr  = addr_q;
  assign cmd_wdata = wdata_q;
  assign resp_ok   = accept && !rsp_err;
  assign resp_fail = accept && rsp_err;
  assign rd_data   = rd_q;

  // R11: the controller never asks for a command while one is in flight
  p_issue_when_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !outst_q);

  // R11: command fields stay put until the completion arrives
  p_hold_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q && !rsp_done) |=> ($stable(addr_q) && $stable(wdata_q) && $stable(write_q)));

  // R11: no new strobe while the previous command is still outstanding
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q && !rsp_done) |=> !valid_q);

endmodule

// File: rtl/phy_init_local_regs.sv
module phy_init_local_regs
  import phy_init_pkg::*;
#(
  parameter int          LREG_W    = 32,
  parameter logic [31:0] MODE_RST  = 32'h0,
  parameter logic [31:0] LOS_RST   = 32'h0,
  parameter logic [31:0] BOOST_RST = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_mode,
  input  logic              set_analog,
  output logic [LREG_W-1:0] mode_cfg,
  output logic [LREG_W-1:0] los_cfg,
  output logic [LREG_W-1:0] boost_cfg
);
  logic [LREG_W-1:0] mode_q,  mode_d;
  logic [LREG_W-1:0] los_q,   los_d;
  logic [LREG_W-1:0] boost_q, boost_d;

  always_comb begin
    mode_d  = mode_q;
    los_d   = los_q;
    boost_d = boost_q;
    mode_d[MODE_LSB +: MODE_W]   = '1;
    los_d[LOSB_LSB +: LOSB_W]    = LOSB_W'(LOSB_VAL);
    los_d[LOSL_LSB +: LOSL_W]    = LOSL_W'(LOSL_VAL);
    boost_d[BOOST_LSB +: BOOST_W] = BOOST_W'(BOOST_VAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= LREG_W'(MODE_RST);
    else if (set_mode) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q   <= LREG_W'(LOS_RST);
      boost_q <= LREG_W'(BOOST_RST);
    end else if (set_analog) begin
      los_q   <= los_d;
      boost_q <= boost_d;
    end
  end

  assign mode_cfg  = mode_q;
  assign los_cfg   = los_q;
  assign boost_cfg = boost_q;

  // R2: once written, the lane-mode field reads as USB3 until reset
  p_mode_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MODE_LSB +: MODE_W] == '1) |=> (mode_q[MODE_LSB +: MODE_W] == '1));

endmodule

// File: rtl/phy_init_ctrl.sv
module phy_init_ctrl
  import phy_init_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             expired,
  input  logic             resp_ok,
  input  logic             resp_fail,
  input  logic [CR_DW-1:0] rd_data,
  output logic             tmr_load,
  output logic             tmr_run,
  output logic             issue,
  output logic             issue_write,
  output logic [CR_AW-1:0] issue_addr,
  output logic [CR_DW-1:0] issue_wdata,
  output logic             set_mode,
  output logic             set_analog,
  output logic             phy_rst,
  output logic             done,
  output logic             error
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_FIXUPS - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              phy_rst_q, done_q, err_q;
  fixup_t            cur;

  always_comb begin
    cur         = fixup_at(step_q);
    issue_addr  = cur.addr;
    issue_wdata = apply_fixup(cur, rd_data);
  end

  always_comb begin
    state_d     = state_q;
    step_d      = step_q;
    step_en     = 1'b0;
    tmr_load    = 1'b0;
    tmr_run     = 1'b0;
    issue       = 1'b0;
    issue_write = 1'b0;
    set_mode    = 1'b0;
    set_analog  = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start) begin
          state_d  = ST_RST;
          tmr_load = 1'b1;
        end
      end
      ST_RST: begin
        tmr_run = 1'b1;
        if (expired) state_d = ST_MODE;
      end
      ST_MODE: begin
        set_mode = 1'b1;
        step_d   = '0;
        step_en  = 1'b1;
        state_d  = ST_RD_ISSUE;
      end
      ST_RD_ISSUE: begin
        issue   = 1'b1;
        state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (resp_fail)    state_d = ST_ERR;
        else if (resp_ok) state_d = ST_WR_ISSUE;
      end
      ST_WR_ISSUE: begin
        issue       = 1'b1;
        issue_write = 1'b1;
        state_d     = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (resp_fail) begin
          state_d = ST_ERR;
        end else if (resp_ok) begin
          if (step_q == LAST_STEP) begin
            state_d = ST_LOCAL;
          end else begin
            step_d  = step_q + 1'b1;
            step_en = 1'b1;
            state_d = ST_RD_ISSUE;
          end
        end
      end
      ST_LOCAL: begin
        set_analog = 1'b1;
        state_d    = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phy_rst_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      phy_rst_q <= (state_d == ST_RST);
      done_q    <= (state_d == ST_DONE);
      err_q     <= (state_d == ST_ERR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  assign phy_rst = phy_rst_q;
  assign done    = done_q;
  assign error   = err_q;

  // R13: reset, finished and failed indications never overlap
  p_status_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_rst_q, done_q, err_q}));

  // R10: a failed run stays failed and quiet until a new start
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start) |=> (err_q && !issue));

  // R13: start has no effect while the run is in progress
  p_busy_ignores_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !phy_rst_q && (state_q != ST_IDLE) && !done_q && !err_q) |=> !phy_rst_q);

  // R3: the step index never runs past the list
  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);

endmodule

// File: rtl/phy_usb3_init_seq.sv
module phy_usb3_init_seq
  import phy_init_pkg::*;
#(
  parameter int          RST_CYCLES = 50,
  parameter int          LREG_W     = 32,
  parameter logic [31:0] MODE_RST   = 32'h0,
  parameter logic [31:0] LOS_RST    = 32'h0,
  parameter logic [31:0] BOOST_RST  = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              phy_rst,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [CR_AW-1:0]  cmd_addr,
  output logic [CR_DW-1:0]  cmd_wdata,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic [CR_DW-1:0]  rsp_rdata,
  output logic [LREG_W-1:0] mode_cfg,
  output logic [LREG_W-1:0] los_cfg,
  output logic [LREG_W-1:0] boost_cfg,
  output logic              done,
  output logic              error
);
  logic             rst_meta_q, rst_sync_q;
  logic             tmr_load, tmr_run, expired;
  logic             issue, issue_write;
  logic [CR_AW-1:0] issue_addr;
  logic [CR_DW-1:0] issue_wdata;
  logic             resp_ok, resp_fail;
  logic [CR_DW-1:0] rd_data;
  logic             set_mode, set_analog;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  phy_init_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .load    (tmr_load),
    .run     (tmr_run),
    .expired (expired)
  );

  phy_init_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .start       (start),
    .expired     (expired),
    .resp_ok     (resp_ok),
    .resp_fail   (resp_fail),
    .rd_data     (rd_data),
    .tmr_load    (tmr_load),
    .tmr_run     (tmr_run),
    .issue       (issue),
    .issue_write (issue_write),
    .issue_addr  (issue_addr),
    .issue_wdata (issue_wdata),
    .set_mode    (set_mode),
    .set_analog  (set_analog),
    .phy_rst     (phy_rst),
    .done        (done),
    .error       (error)
  );

  phy_init_cr_port u_port (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .issue       (issue),
    .issue_write (issue_write),
    .issue_addr  (issue_addr),
    .issue_wdata (issue_wdata),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .resp_ok     (resp_ok),
    .resp_fail   (resp_fail),
    .rd_data     (rd_data)
  );

  phy_init_local_regs #(
    .LREG_W    (LREG_W),
    .MODE_RST  (MODE_RST),
    .LOS_RST   (LOS_RST),
    .BOOST_RST (BOOST_RST)
  ) u_lregs (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .set_mode   (set_mode),
    .set_analog (set_analog),
    .mode_cfg   (mode_cfg),
    .los_cfg    (los_cfg),
    .boost_cfg  (boost_cfg)
  );

  // R2: the PHY is never addressed while it is held in reset
  p_no_cmd_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    phy_rst |-> !cmd_valid);

  // R9: analog settings move only in the cycle that reports completion
  p_analog_at_end_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!$stable(los_cfg) || !$stable(boost_cfg)) |-> done);

  // R10: a failed run leaves no command strobe behind
  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    error |-> !cmd_valid);

endmodule

// File: tb/phy_usb3_init_seq_bench.sv
module phy_usb3_init_seq_bench;
  localparam int          RST_CYC   = 6;
  localparam logic [31:0] MODE_RST  = 32'h1234_0F9F;
  localparam logic [31:0] LOS_RST   = 32'hA5A5_A5A5;
  localparam logic [31:0] BOOST_RST = 32'h5A5A_5A5A;
  localparam int          WATCHDOG  = 150000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        phy_rst;
  logic        cmd_valid, cmd_write;
  logic [15:0] cmd_addr, cmd_wdata;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [31:0] mode_cfg, los_cfg, boost_cfg;
  logic        done, error;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bus master model state
  logic [15:0] mem [0:5];
  logic [15:0] log_addr [0:31];
  logic        log_wr   [0:31];
  logic [15:0] log_data [0:31];
  logic [31:0] snap_mode, snap_los, snap_boost;
  logic        snap_rst;
  int op_cnt = 0;
  int lat = 1;
  int err_at = -1;
  int viol = 0;
  int spur_req = 0;
  int spur_served = 0;

  phy_usb3_init_seq #(
    .RST_CYCLES (RST_CYC),
    .LREG_W     (32),
    .MODE_RST   (MODE_RST),
    .LOS_RST    (LOS_RST),
    .BOOST_RST  (BOOST_RST)
  ) u_phy_usb3_init_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phy_rst   (phy_rst),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .mode_cfg  (mode_cfg),
    .los_cfg   (los_cfg),
    .boost_cfg (boost_cfg),
    .done      (done),
    .error     (error)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] addr_of(input int step);
    case (step)
      0: return 16'h102D;
      1: return 16'h1010;
      2: return 16'h1006;
      3: return 16'h1002;
      default: return 16'h0030;
    endcase
  endfunction

  function automatic int slot_of(input logic [15:0] a);
    for (int s = 0; s < 5; s++) if (addr_of(s) == a) return s;
    return 5;
  endfunction

  // expected write value for each step, built field by field
  function automatic logic [15:0] exp_write(input int step, input logic [15:0] r);
    logic [15:0] e;
    e = r;
    case (step)
      0: e[7] = 1'b1;
      1: begin e[11:4] = 8'h00; e = e | 16'd20; end
      2: begin e[6] = 1'b0; e[7] = 1'b1; e[10:8] = 3'd3; e[11] = 1'b1; end
      3: begin e[6:0] = 7'd127; e[13:7] = 7'd22; e[14] = 1'b1; end
      default: e[7:4] = 4'd8;
    endcase
    return e;
  endfunction

  function automatic logic [31:0] exp_mode();
    logic [31:0] v;
    v = MODE_RST;
    v[6:5] = 2'b11;
    return v;
  endfunction

  function automatic logic [31:0] exp_los();
    logic [31:0] v;
    v = LOS_RST;
    v[23:21] = 3'd4;
    v[20:16] = 5'd9;
    return v;
  endfunction

  function automatic logic [31:0] exp_boost();
    logic [31:0] v;
    v = BOOST_RST;
    v[20:18] = 3'd4;
    return v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // bus master model
  initial begin
    rsp_done  = 1'b0;
    rsp_err   = 1'b0;
    rsp_rdata = 16'h0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        automatic int idx = op_cnt;
        automatic logic [15:0] a = cmd_addr;
        automatic logic [15:0] d = cmd_wdata;
        automatic logic        w = cmd_write;
        if (idx < 32) begin
          log_addr[idx] = a;
          log_wr[idx]   = w;
          log_data[idx] = w ? d : mem[slot_of(a)];
        end
        if (idx == 0) begin
          snap_mode  = mode_cfg;
          snap_los   = los_cfg;
          snap_boost = boost_cfg;
          snap_rst   = phy_rst;
        end
        op_cnt = op_cnt + 1;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (cmd_valid || cmd_addr !== a || cmd_wdata !== d || cmd_write !== w) viol++;
        end
        rsp_rdata = w ? 16'hFFFF : mem[slot_of(a)];
        rsp_err   = (idx == err_at);
        rsp_done  = 1'b1;
        if (w && idx != err_at) mem[slot_of(a)] = d;
        @(negedge clk);
        rsp_done  = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = 16'h0;
      end else if (rst_n && spur_req != spur_served) begin
        rsp_done = 1'b1;
        rsp_err  = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        rsp_err  = 1'b0;
        spur_served++;
      end
    end
  end

  task automatic load_mem(input logic [15:0] pat);
    for (int s = 0; s < 5; s++) mem[s] = pat ^ (16'h1111 * s[15:0]);
    mem[5] = 16'h0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    op_cnt = 0;
    check("R1", "reset phy_rst", {31'b0, phy_rst}, 32'd0);
    check("R13", "reset done/error", {30'b0, done, error}, 32'd0);
    check("R11", "reset cmd_valid", {31'b0, cmd_valid}, 32'd0);
    check("R2", "reset mode_cfg", mode_cfg, MODE_RST);
    check("R9", "reset los/boost", los_cfg ^ boost_cfg, LOS_RST ^ BOOST_RST);
  endtask

  // pulse start and measure the PHY reset width
  task automatic kick(input bit spurious);
    int w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (spurious) spur_req++;
    w = 0;
    while (phy_rst && w < 1000) begin
      w++;
      @(negedge clk);
    end
    check("R1", "phy_rst width", w, RST_CYC);
  endtask

  task automatic finish_run(input bit exp_ok, input int fail_at, input bit check_snap);
    int n;
    int exp_n;
    int bad_order;
    n = 0;
    while (!(done || error) && n < 2000) begin
      n++;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check(exp_ok ? "R9" : "R10", "done", {31'b0, done}, {31'b0, exp_ok});
    check("R10", "error", {31'b0, error}, {31'b0, !exp_ok});
    exp_n = exp_ok ? 10 : fail_at + 1;
    check(exp_ok ? "R3" : "R10", "command count", op_cnt, exp_n);
    bad_order = 0;
    for (int i = 0; i < op_cnt && i < 32; i++)
      if (log_addr[i] !== addr_of(i / 2) || log_wr[i] !== i[0]) bad_order++;
    check("R3", "command order", bad_order, 0);
    for (int i = 1; i < op_cnt && i < 10; i += 2) begin
      automatic int st = i / 2;
      automatic string tg = (st == 0) ? "R4" : (st == 1) ? "R5" : (st == 2) ? "R6" :
                            (st == 3) ? "R7" : "R8";
      check(tg, "fixup write data", {16'h0, log_data[i]},
            {16'h0, exp_write(st, log_data[i-1])});
    end
    check("R2", "final mode_cfg", mode_cfg, exp_mode());
    check(exp_ok ? "R9" : "R10", "final los_cfg", los_cfg, exp_ok ? exp_los() : LOS_RST);
    check(exp_ok ? "R9" : "R10", "final boost_cfg", boost_cfg, exp_ok ? exp_boost() : BOOST_RST);
    if (check_snap) begin
      check("R2", "phy_rst at first command", {31'b0, snap_rst}, 32'd0);
      check("R2", "mode_cfg at first command", snap_mode, exp_mode());
      check("R9", "los_cfg before analog step", snap_los, LOS_RST);
      check("R9", "boost_cfg before analog step", snap_boost, BOOST_RST);
    end
  endtask

  initial begin
    logic [15:0] pats [0:4];
    rst_n = 1'b0;
    start = 1'b0;
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5;
    pats[3] = 16'h5A5A; pats[4] = 16'h1234;

    // sweep patterns and response latencies on clean runs
    for (int p = 0; p < 5; p++) begin
      for (int l = 0; l < 4; l++) begin
        lat = l;
        err_at = -1;
        load_mem(pats[p]);
        do_reset();
        kick(1'b0);
        finish_run(1'b1, 0, 1'b1);
      end
    end

    // error injected at each command position
    for (int k = 0; k < 10; k++) begin
      lat = 1 + (k % 3);
      err_at = k;
      load_mem(16'hC3C3);
      do_reset();
      kick(1'b0);
      finish_run(1'b0, k, 1'b1);
    end

    // R12: stray completion with error while nothing is outstanding
    lat = 2;
    err_at = -1;
    load_mem(16'h0F0F);
    do_reset();
    kick(1'b1);
    finish_run(1'b1, 0, 1'b1);

    // R13: start mid-run is ignored, then restart after completion
    lat = 1;
    load_mem(16'h3C3C);
    do_reset();
    kick(1'b0);
    while (op_cnt < 3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R13", "phy_rst after busy start", {31'b0, phy_rst}, 32'd0);
    end
    finish_run(1'b1, 0, 1'b1);
    op_cnt = 0;
    kick(1'b0);
    check("R13", "done cleared by restart", {31'b0, done}, 32'd0);
    finish_run(1'b1, 0, 1'b0);

    check("R11", "command strobe or fields moved while outstanding", viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule